// File: doc/BRIEF.md
# Endpoint Interrupt Flag and Enable Controller

This block keeps the interrupt state of a single USB device endpoint. Pulses from the endpoint's transfer logic set eight sticky flags: OUT packet received, transmit bank free, STALL sent or isochronous CRC error, setup packet received, NAK returned to an IN token, NAK returned to an OUT token, bank overflow and bank underflow. Software reaches the flags and a matching set of enables through a small 8-bit register port. A flag is acknowledged by writing zero to its position, and writing one leaves it as it is.

One registered interrupt request leaves the block. It is the OR of every set flag whose enable is on, gated by a global interrupt enable input. A single enable covers both flow-error flags. When the endpoint runs in the IN direction, the bit position of the OUT-received flag changes role. Writing one there sends a one-cycle command that discards the most recently loaded bank, and writing zero there no longer clears the flag.

Top module: `ep_irq_ctrl`

## Requirements
- R1: After reset every flag, every enable, `ep_irq` and `kill_bank` are 0.
- R2: A 1 on `hw_evt[i]` sets flag i at the next clock edge, and the flag reads back at `reg_rdata` when `reg_sel`=0. The flag bit positions are: 7 overflow, 6 NAK-IN, 5 underflow, 4 NAK-OUT, 3 setup received, 2 OUT received, 1 stalled, 0 transmit ready.
- R3: A write with `reg_sel`=0 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. When `dir_in`=0 this also holds for bit 2.
- R4: When a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R5: A write with `reg_sel`=1 loads the enables, and they read back with `reg_sel`=1. The enable bit positions are: 7 flow error, 6 NAK-IN, 4 NAK-OUT, 3 setup, 2 OUT received, 1 stalled, 0 transmit ready. Bit 5 always reads 0 and ignores writes.
- R6: `ep_irq` goes to 1 one cycle after a state in which `glob_ie`=1 and some flag and its enable are both 1. It is 0 one cycle after a state with `glob_ie`=0 or with no enabled flag set.
- R7: Enable bit 7 enables the interrupt for both the overflow flag (bit 7) and the underflow flag (bit 5).
- R8: With `dir_in`=1, a flag write with data bit 2 = 1 drives `kill_bank` high for exactly the one cycle after the write edge. With `dir_in`=0 the same write gives no pulse.
- R9: With `dir_in`=1, a flag write with data bit 2 = 0 leaves the OUT-received flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glob_ie | input | 1 | Global interrupt enable |
| dir_in | input | 1 | 1 = IN endpoint (bit 2 becomes the bank-kill command) |
| hw_evt | input | 8 | Event pulses, one per flag position |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = flag register, 1 = enable register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| ep_irq | output | 1 | Registered endpoint interrupt request |
| kill_bank | output | 1 | One-cycle command to discard the last loaded bank |

## Verification
Flags and enables change at the edge that captures the event or the write, so the bench reads them back in the half cycle after that edge. `ep_irq` sits one register further on and is due one edge after the flag or enable it depends on. The bench therefore checks it one full cycle after the event edge. `kill_bank` is high only in the cycle that follows the write edge, so the bench samples it both in that cycle and in the next one. Inputs are driven and outputs sampled on the falling edge.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;
    localparam int REG_W = 8;

    // flag positions
    localparam int BIT_TXRDY  = 0;
    localparam int BIT_STALL  = 1;
    localparam int BIT_RXOUT  = 2;
    localparam int BIT_SETUP  = 3;
    localparam int BIT_NAKOUT = 4;
    localparam int BIT_UNF    = 5;
    localparam int BIT_NAKIN  = 6;
    localparam int BIT_OVF    = 7;

    // enable positions that differ from the flag positions
    localparam int EN_RSVD = 5;
    localparam int EN_FLOW = 7;

    localparam logic [REG_W-1:0] EN_RSVD_MASK = REG_W'(1) << EN_RSVD;

    typedef struct packed {
        logic [REG_W-1:0] flags;
        logic             kill;
    } flag_state_t;

    typedef struct packed {
        logic [REG_W-1:0] en;
    } en_state_t;

    typedef struct packed {
        logic irq;
    } irq_state_t;
endpackage

// File: rtl/ep_flag_bank.sv
module ep_flag_bank
    import ep_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] hw_evt,
    input  logic             wr_flags,
    input  logic [REG_W-1:0] wr_data,
    input  logic             dir_in,
    output logic [REG_W-1:0] flags_q,
    output logic             kill_q
);
    flag_state_t state_d, state_q;
    logic [REG_W-1:0] clr_allow;
    logic [REG_W-1:0] clr_mask;

    // The OUT-received position is protected from clearing in IN mode.
    for (genvar g = 0; g < REG_W; g++) begin : g_allow
        if (g == BIT_RXOUT) begin : g_shared
            assign clr_allow[g] = ~dir_in;
        end else begin : g_plain
            assign clr_allow[g] = 1'b1;
        end
    end

    always_comb begin
        state_d      = state_q;
        state_d.kill = 1'b0;
        clr_mask     = '0;
        if (wr_flags) begin
            clr_mask = ~wr_data & clr_allow;
        end
        // a set event outranks a clear in the same cycle
        state_d.flags = hw_evt | (state_q.flags & ~clr_mask);
        if (wr_flags && dir_in && wr_data[BIT_RXOUT]) begin
            state_d.kill = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags_q = state_q.flags;
    assign kill_q  = state_q.kill;
endmodule

// File: rtl/ep_enable_reg.sv
module ep_enable_reg
    import ep_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_reg,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] en_q
);
    en_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en_reg) begin
            state_d.en = wr_data & ~EN_RSVD_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign en_q = state_q.en;
endmodule

// File: rtl/ep_irq_combiner.sv
module ep_irq_combiner
    import ep_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glob_ie,
    input  logic [REG_W-1:0] flags,
    input  logic [REG_W-1:0] en,
    output logic             irq_q
);
    irq_state_t state_d, state_q;
    logic [REG_W-1:0] en_mask;

    // Map each flag onto its enable; the underflow flag shares the flow-error enable.
    for (genvar g = 0; g < REG_W; g++) begin : g_map
        if (g == BIT_UNF) begin : g_flow
            assign en_mask[g] = en[EN_FLOW];
        end else begin : g_direct
            assign en_mask[g] = en[g];
        end
    end

    always_comb begin
        state_d     = state_q;
        state_d.irq = glob_ie & (|(flags & en_mask));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_q = state_q.irq;
endmodule

// File: rtl/ep_irq_ctrl.sv
module ep_irq_ctrl
    import ep_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glob_ie,
    input  logic             dir_in,
    input  logic [REG_W-1:0] hw_evt,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             ep_irq,
    output logic             kill_bank
);
    logic [REG_W-1:0] flags_q;
    logic [REG_W-1:0] en_q;
    logic             wr_flags;
    logic             wr_en_reg;

    assign wr_flags  = reg_wr & ~reg_sel;
    assign wr_en_reg = reg_wr &  reg_sel;

    ep_flag_bank u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_evt   (hw_evt),
        .wr_flags (wr_flags),
        .wr_data  (reg_wdata),
        .dir_in   (dir_in),
        .flags_q  (flags_q),
        .kill_q   (kill_bank)
    );

    ep_enable_reg u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_reg (wr_en_reg),
        .wr_data   (reg_wdata),
        .en_q      (en_q)
    );

    ep_irq_combiner u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .glob_ie (glob_ie),
        .flags   (flags_q),
        .en      (en_q),
        .irq_q   (ep_irq)
    );

    assign reg_rdata = reg_sel ? en_q : flags_q;
endmodule

// File: rtl/ep_irq_ctrl_chk.sv
module ep_irq_ctrl_chk
    import ep_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             glob_ie,
    input logic             dir_in,
    input logic [REG_W-1:0] hw_evt,
    input logic             reg_wr,
    input logic             reg_sel,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             ep_irq,
    input logic             kill_bank,
    input logic [REG_W-1:0] flags_q,
    input logic [REG_W-1:0] en_q
);
    // R2 / R4: every event bit is set in the next cycle, whatever is written
    p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_evt) |=> ((flags_q & $past(hw_evt)) == $past(hw_evt)));

    // R3: writing all ones changes no flag
    p_write_one_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && reg_wdata == '1 && hw_evt == '0) |=> (flags_q == $past(flags_q)));

    // R5: the reserved enable bit reads as zero
    p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> !reg_rdata[EN_RSVD]);

    // R6: no interrupt without the global enable one cycle earlier
    p_irq_needs_gie_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ep_irq |-> $past(glob_ie));

    // R6: an enabled transmit-ready flag raises the request in the next cycle
    p_irq_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_ie && flags_q[BIT_TXRDY] && en_q[BIT_TXRDY]) |=> ep_irq);

    // R7: underflow is covered by the flow-error enable
    p_flow_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_ie && flags_q[BIT_UNF] && en_q[EN_FLOW]) |=> ep_irq);

    // R8: the kill pulse only follows an IN-mode write of one to bit 2
    p_kill_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        kill_bank |-> $past(dir_in && reg_wr && !reg_sel && reg_wdata[BIT_RXOUT]));

    // R9: in IN mode a zero write cannot clear the OUT-received flag
    p_in_no_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_in && reg_wr && !reg_sel && !reg_wdata[BIT_RXOUT] && flags_q[BIT_RXOUT])
        |=> flags_q[BIT_RXOUT]);
endmodule

bind ep_irq_ctrl ep_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .glob_ie   (glob_ie),
    .dir_in    (dir_in),
    .hw_evt    (hw_evt),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ep_irq    (ep_irq),
    .kill_bank (kill_bank),
    .flags_q   (flags_q),
    .en_q      (en_q)
);

// File: tb/ep_irq_ctrl_test.sv
module ep_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       glob_ie = 1'b0;
    logic       dir_in = 1'b0;
    logic [7:0] hw_evt = '0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ep_irq;
    logic       kill_bank;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    ep_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .glob_ie(glob_ie), .dir_in(dir_in),
        .hw_evt(hw_evt), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ep_irq(ep_irq), .kill_bank(kill_bank)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        reg_sel = sel;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [7:0] e);
        @(negedge clk);
        hw_evt = e;
        @(negedge clk);
        hw_evt = '0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++; checks++;
                $display("FAIL watchdog actual=%0d expected<=100000", cycles);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(1'b0, v); check("R1 flags", v, 8'h00);
        rd(1'b1, v); check("R1 enables", v, 8'h00);
        check("R1 irq", {7'd0, ep_irq}, 8'h00);
        check("R1 kill", {7'd0, kill_bank}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 enable readback, reserved bit
        wr(1'b1, 8'hFF); rd(1'b1, v); check("R5 all ones", v, 8'hDF);
        wr(1'b1, 8'h5A); rd(1'b1, v); check("R5 pattern", v, 8'h5A);
        wr(1'b1, 8'h20); rd(1'b1, v); check("R5 reserved only", v, 8'h00);

        // R2 / R6 / R7 sweep: flag i against enable j, global on and off
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                for (int g = 0; g < 2; g++) begin
                    int pair;
                    logic expv;
                    pair = (i == 5) ? 7 : i;
                    expv = (g == 1) && (j == pair) && (j != 5);
                    wr(1'b0, 8'h00);
                    wr(1'b1, 8'(1 << j));
                    glob_ie = g[0];
                    pulse(8'(1 << i));
                    if (j == 0 && g == 0) begin
                        rd(1'b0, v); check("R2 flag position", v, 8'(1 << i));
                    end
                    @(negedge clk);
                    if (i == 5 || i == 7)
                        check("R7 flow enable", {7'd0, ep_irq}, {7'd0, expv});
                    else
                        check("R6 irq gating", {7'd0, ep_irq}, {7'd0, expv});
                end
            end
        end
        glob_ie = 1'b0;
        wr(1'b1, 8'h00);

        // R3 write-one keeps, write-zero clears (OUT mode)
        pulse(8'hFF);
        wr(1'b0, 8'hFF); rd(1'b0, v); check("R3 ones keep", v, 8'hFF);
        wr(1'b0, 8'hF0); rd(1'b0, v); check("R3 zeros clear", v, 8'hF0);
        wr(1'b0, 8'h00); rd(1'b0, v); check("R3 clear all", v, 8'h00);

        // R4 set wins over clear in the same cycle
        pulse(8'hFF);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h00; hw_evt = 8'h11;
        @(negedge clk);
        reg_wr = 1'b0; hw_evt = '0;
        rd(1'b0, v); check("R4 set wins", v, 8'h11);

        // R8 kill pulse in IN mode
        wr(1'b0, 8'h00);
        dir_in = 1'b1;
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h04;
        @(negedge clk);
        reg_wr = 1'b0;
        check("R8 kill high", {7'd0, kill_bank}, 8'h01);
        @(negedge clk);
        check("R8 kill one cycle", {7'd0, kill_bank}, 8'h00);
        // R8 no pulse in OUT mode
        dir_in = 1'b0;
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h04;
        @(negedge clk);
        reg_wr = 1'b0;
        check("R8 no kill OUT mode", {7'd0, kill_bank}, 8'h00);

        // R9 zero write does not clear bit 2 in IN mode
        pulse(8'h07);
        dir_in = 1'b1;
        wr(1'b0, 8'h00); rd(1'b0, v); check("R9 bit2 held", v, 8'h04);
        dir_in = 1'b0;
        wr(1'b0, 8'h00); rd(1'b0, v); check("R3 bit2 clears OUT mode", v, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule